// File: doc/BRIEF.md
# Wake-up Exit Delay Sequencer

This block controls the return from a low-power sleep or idle state to instruction execution. A single-cycle wake pulse carries two codes. The first says which clock was running before wake-up. The second says which clock mode the core will run from afterwards. The block decodes the pair into a set of delay lengths, given in clock cycles. It then runs one down-counter for each delay and raises a CPU run enable once the delays that block execution have finished.

A fixed CPU-preparation delay is applied on every wake. It runs in parallel with any oscillator start-up or PLL lock delay, and the longer of the two decides when execution resumes. Two status flags report clock readiness. The crystal-ready flag covers crystal targets. The fast-internal-stable flag covers the internal fast oscillator. The internal-oscillator stabilisation period only sets its own flag and never holds execution off. After wake-up the block stays in its run state until the next synchronous reset.

Throughout this brief, "cycle n" means the state seen just after the n-th rising clock edge following the edge that samples `wake_i`. That sampling edge is cycle 0.

Top module: `wake_exit_seq`

## Requirements
- R1: While `rst` is high, and after it is released until a wake pulse is sampled, `run_en_o`, `osc_ready_o` and `iosc_stable_o` are all low.
- R2: For targets that need no start-up delay, `run_en_o` rises at cycle CSD_CYC+1 after wake. These are target codes 4 (external clock), 5 (RC), 6 (31 kHz internal RC) and 7 (fast internal oscillator), or any crystal target woken from prior code 0.
- R3: For target codes 0, 1 and 2 (crystal low, medium and high speed) with prior codes 1 (secondary or low-frequency RC), 2 (fast internal) or 3 (none, full sleep), `osc_ready_o` rises at cycle OST_CYC and `run_en_o` rises at cycle max(CSD_CYC, OST_CYC)+1.
- R4: For target code 3 (crystal with PLL) with prior code 1, 2 or 3, `osc_ready_o` rises at cycle OST_CYC+PLL_CYC and `run_en_o` rises at cycle max(CSD_CYC, OST_CYC+PLL_CYC)+1.
- R5: With prior code 0 (primary clock still running in idle) and a target code from 0 to 3, no start-up time applies. `osc_ready_o` is high from cycle 0 and `run_en_o` rises at cycle CSD_CYC+1.
- R6: For target code 7 with prior code 1 or 3, `iosc_stable_o` rises at cycle IOB_CYC. `run_en_o` still rises at cycle CSD_CYC+1, whatever the value of IOB_CYC.
- R7: For target code 7 with prior code 0 or 2, no stabilisation applies and `iosc_stable_o` is high from cycle 0 onward.
- R8: `osc_ready_o` never rises for target codes 4 to 7. `iosc_stable_o` never rises for target codes 0 to 6, so target code 6 has no status flag at all.
- R9: A wake pulse sampled while a sequence is running, or after `run_en_o` has risen, is ignored, whatever codes it carries. All output timing and values stay as set by the first wake.
- R10: Once high, `run_en_o`, `osc_ready_o` and `iosc_stable_o` stay high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; returns the block to the sleeping state |
| wake_i | input | 1 | Wake event, sampled on the rising edge |
| prior_src_i | input | 2 | Clock running before wake: 0 primary idle, 1 secondary or low-frequency RC, 2 fast internal, 3 none |
| target_i | input | 3 | Clock mode after wake: 0..2 crystal low/medium/high, 3 crystal with PLL, 4 external, 5 RC, 6 31 kHz RC, 7 fast internal |
| run_en_o | output | 1 | CPU run enable |
| osc_ready_o | output | 1 | Crystal oscillator ready flag |
| iosc_stable_o | output | 1 | Fast internal oscillator stable flag |

## Verification
The assertions assume two things about the inputs. The source and target codes are valid and free of X whenever `wake_i` is high. The only way back to the sleeping state is reset. The stimulus respects both. Every source and target pair starts from a fresh reset. All inputs change only on the falling clock edge. A wake pulse is held for exactly one cycle with its codes stable. Late wake pulses carry deliberately different codes, so that ignoring them can be seen at the ports.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;

  typedef enum logic [1:0] {
    SRC_PRI_IDLE = 2'd0,
    SRC_SLOW     = 2'd1,
    SRC_FAST_INT = 2'd2,
    SRC_NONE     = 2'd3
  } prior_src_e;

  typedef enum logic [2:0] {
    TGT_XT_LO    = 3'd0,
    TGT_XT_MID   = 3'd1,
    TGT_XT_HI    = 3'd2,
    TGT_XT_PLL   = 3'd3,
    TGT_EXT      = 3'd4,
    TGT_RC       = 3'd5,
    TGT_LF_RC    = 3'd6,
    TGT_FAST_INT = 3'd7
  } tgt_mode_e;

  typedef enum logic [1:0] {
    ST_ASLEEP = 2'd0,
    ST_WAKING = 2'd1,
    ST_RUN    = 2'd2
  } seq_state_e;

  // timer slots
  localparam int NUM_TMR  = 3;
  localparam int TMR_PREP = 0;
  localparam int TMR_OSC  = 1;
  localparam int TMR_IOSC = 2;

  function automatic logic is_xtal(input tgt_mode_e t);
    return (t == TGT_XT_LO) || (t == TGT_XT_MID) ||
           (t == TGT_XT_HI) || (t == TGT_XT_PLL);
  endfunction

endpackage

// File: rtl/exit_delay_plan.sv
`timescale 1ns/1ps
module exit_delay_plan
  import wake_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int CSD_CYC = 5,
  parameter int OST_CYC = 12,
  parameter int PLL_CYC = 7,
  parameter int IOB_CYC = 9
) (
  input  prior_src_e                         prior_i,
  input  tgt_mode_e                          tgt_i,
  output logic [NUM_TMR-1:0][CNT_W-1:0]      len_o
);

  localparam logic [CNT_W-1:0] L_PREP = CNT_W'(CSD_CYC);
  localparam logic [CNT_W-1:0] L_XT   = CNT_W'(OST_CYC);
  localparam logic [CNT_W-1:0] L_PLL  = CNT_W'(OST_CYC + PLL_CYC);
  localparam logic [CNT_W-1:0] L_IOB  = CNT_W'(IOB_CYC);

  always_comb begin
    len_o = '0;
    // CPU preparation always applies
    len_o[TMR_PREP] = L_PREP;
    // start-up timer only when the primary clock is not already running
    if (is_xtal(tgt_i) && (prior_i != SRC_PRI_IDLE)) begin
      len_o[TMR_OSC] = (tgt_i == TGT_XT_PLL) ? L_PLL : L_XT;
    end
    // stabilisation only when coming from a slow clock or full sleep
    if ((tgt_i == TGT_FAST_INT) &&
        ((prior_i == SRC_SLOW) || (prior_i == SRC_NONE))) begin
      len_o[TMR_IOSC] = L_IOB;
    end
  end

endmodule

// File: rtl/delay_timer.sv
`timescale 1ns/1ps
module delay_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= len_i;
      done_o <= (len_i == '0);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) done_o <= 1'b1;
    end
  end

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_i && done_o) |=> done_o);

endmodule

// File: rtl/wake_exit_seq.sv
`timescale 1ns/1ps
module wake_exit_seq
  import wake_pkg::*;
#(
  parameter int CSD_CYC = 5,
  parameter int OST_CYC = 12,
  parameter int PLL_CYC = 7,
  parameter int IOB_CYC = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wake_i,
  input  logic [1:0] prior_src_i,
  input  logic [2:0] target_i,
  output logic       run_en_o,
  output logic       osc_ready_o,
  output logic       iosc_stable_o
);

  localparam int OSC_MAX = OST_CYC + PLL_CYC;
  localparam int LONG_A  = (CSD_CYC > OSC_MAX) ? CSD_CYC : OSC_MAX;
  localparam int LONGEST = (LONG_A > IOB_CYC) ? LONG_A : IOB_CYC;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  seq_state_e                    state_q;
  tgt_mode_e                     tgt_q;
  logic                          wake_go;
  logic [NUM_TMR-1:0][CNT_W-1:0] len_w;
  logic [NUM_TMR-1:0]            done_w;

  assign wake_go = (state_q == ST_ASLEEP) && wake_i;

  exit_delay_plan #(
    .CNT_W  (CNT_W),
    .CSD_CYC(CSD_CYC),
    .OST_CYC(OST_CYC),
    .PLL_CYC(PLL_CYC),
    .IOB_CYC(IOB_CYC)
  ) u_plan (
    .prior_i(prior_src_e'(prior_src_i)),
    .tgt_i  (tgt_mode_e'(target_i)),
    .len_o  (len_w)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    delay_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .load_i(wake_go),
      .len_i (len_w[g]),
      .done_o(done_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ASLEEP;
      tgt_q   <= TGT_LF_RC;
    end else begin
      case (state_q)
        ST_ASLEEP: if (wake_i) begin
          state_q <= ST_WAKING;
          tgt_q   <= tgt_mode_e'(target_i);
        end
        ST_WAKING: if (done_w[TMR_PREP] && done_w[TMR_OSC]) state_q <= ST_RUN;
        default:   state_q <= ST_RUN;
      endcase
    end
  end

  assign run_en_o      = (state_q == ST_RUN);
  assign osc_ready_o   = (state_q != ST_ASLEEP) && is_xtal(tgt_q) && done_w[TMR_OSC];
  assign iosc_stable_o = (state_q != ST_ASLEEP) && (tgt_q == TGT_FAST_INT) && done_w[TMR_IOSC];

  // R2
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en_o) |-> $past(done_w[TMR_PREP] && done_w[TMR_OSC]));

  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    run_en_o |=> run_en_o);

  // R9
  wake_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q != ST_ASLEEP) && wake_i) |=> ($stable(tgt_q) && (state_q != ST_ASLEEP)));

  // R3
  xtal_before_run_chk: assert property (@(posedge clk) disable iff (rst)
    (run_en_o && is_xtal(tgt_q)) |-> osc_ready_o);

  // R1
  asleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ASLEEP) |-> !(run_en_o || osc_ready_o || iosc_stable_o));

endmodule

// File: tb/test_wake_exit_seq.sv
`timescale 1ns/1ps
module test_wake_exit_seq;

  localparam int CSD = 5;
  localparam int OST = 12;
  localparam int PLL = 7;
  localparam int IOB = 9;
  localparam int WIN = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wake = 1'b0;
  logic [1:0] prior = 2'd0;
  logic [2:0] tgt = 3'd0;
  logic       run_en, osc_rdy, iosc_st;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  wake_exit_seq #(
    .CSD_CYC(CSD), .OST_CYC(OST), .PLL_CYC(PLL), .IOB_CYC(IOB)
  ) i_wake_exit_seq (
    .clk(clk), .rst(rst), .wake_i(wake), .prior_src_i(prior),
    .target_i(tgt), .run_en_o(run_en), .osc_ready_o(osc_rdy),
    .iosc_stable_o(iosc_st)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic run_pair(input int p, input int t, input bit late_wake);
    bit xt, pll, fast;
    int losc, liob, drun;
    string run_tag, osc_tag, io_tag;
    xt   = (t <= 3);
    pll  = (t == 3);
    fast = (t == 7);
    losc = (xt && p != 0) ? (OST + (pll ? PLL : 0)) : 0;
    liob = (fast && (p == 1 || p == 3)) ? IOB : 0;
    drun = ((CSD > losc) ? CSD : losc) + 1;
    run_tag = !xt ? (liob > 0 ? "R6" : "R2") : (p == 0 ? "R5" : (pll ? "R4" : "R3"));
    osc_tag = !xt ? "R8" : run_tag;
    io_tag  = !fast ? "R8" : (liob > 0 ? "R6" : "R7");
    if (late_wake) begin
      run_tag = "R9"; osc_tag = "R9"; io_tag = "R9";
    end
    // reset and idle
    @(negedge clk);
    rst = 1'b1; wake = 1'b0;
    @(negedge clk);
    chk("R1", "run_en in reset", run_en, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R1", "run_en idle", run_en, 1'b0);
      chk("R1", "osc_ready idle", osc_rdy, 1'b0);
      chk("R1", "iosc_stable idle", iosc_st, 1'b0);
    end
    // wake pulse, sampled at edge cycle 0
    wake = 1'b1; prior = 2'(p); tgt = 3'(t);
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      wake = 1'b0;
      if (late_wake && (k == 2 || k == 25)) begin
        wake = 1'b1; prior = 2'(~p); tgt = 3'(~t);
      end
      chk((k > drun && !late_wake) ? "R10" : run_tag, "run_en", run_en, (k >= drun));
      chk((k > losc && xt && !late_wake) ? "R10" : osc_tag, "osc_ready", osc_rdy, (xt && k >= losc));
      chk((k > liob && fast && !late_wake) ? "R10" : io_tag, "iosc_stable", iosc_st, (fast && k >= liob));
    end
    wake = 1'b0;
  endtask

  initial begin
    for (int pass = 0; pass < 2; pass++)
      for (int p = 0; p < 4; p++)
        for (int t = 0; t < 8; t++)
          run_pair(p, t, pass == 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule